// File: doc/BRIEF.md
# Thermal Clock-Modulation Duty-Cycle Gate

This block throttles a processor core once lowering frequency and voltage has failed to end a thermal event. It watches an over-temperature flag and a flag that says the frequency and voltage targets are already at their floor. When both are high, it starts driving a clock-enable waveform. The waveform is on for a quarter of each period and off for the remaining three quarters.

The period is counted in pulses of a fixed-rate reference tick, so it does not depend on the core clock frequency. With the defaults (a 1 MHz tick, 8 enabled ticks out of 32), each period lasts 32 µs. The tick is a one-cycle pulse that is already synchronous to the block clock.

A hysteresis timer keeps throttling in place for a programmable number of ticks after the temperature drops. If the temperature rises again, the timer restarts. Throttling ends only at the close of a full period, so the last pulse is never cut short. While throttling is off, the enable stays high. A downstream glitch-free gate cell consumes the enable.

Top module: `thermal_clkmod_gate`

## Requirements
- R1: After synchronous reset, `clk_en` is 1 and `throttle_on` is 0.
- R2: Whenever `throttle_on` is 0, `clk_en` is 1.
- R3: Throttling starts only on a clock edge where `over_temp` and `fv_at_min` are both 1. Either flag alone leaves `throttle_on` at 0.
- R4: `throttle_on` rises in the cycle after the engaging edge. Each period begins with its enabled part, so `clk_en` is 1 in that cycle.
- R5: While throttling, the phase advances by one on each `ref_tick` pulse, and only on such a pulse. Phases 0 to ON_TICKS-1 give `clk_en` = 1. Phases ON_TICKS to PERIOD_TICKS-1 give `clk_en` = 0. After phase PERIOD_TICKS-1 the phase wraps to 0.
- R6: The hysteresis count is reloaded to HYST_TICKS on every edge where `over_temp` is 1 and the block is throttling or engaging. Otherwise it drops by one on each `ref_tick` while throttling, until it reaches zero.
- R7: Throttling ends only on a `ref_tick` that falls in phase PERIOD_TICKS-1, and only if at that edge `over_temp` is 0 and the hysteresis count is already zero.
- R8: Once throttling has started, dropping `fv_at_min` has no effect on `throttle_on` or `clk_en`.
- R9: Both outputs are registered. On the edge that ends throttling, `clk_en` returns to 1 and `throttle_on` falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| over_temp | input | 1 | Temperature is above the maximum limit |
| fv_at_min | input | 1 | Frequency and voltage targets are at their minimum |
| ref_tick | input | 1 | One-cycle pulse from the fixed-rate timebase |
| clk_en | output | 1 | Clock-enable waveform for the downstream gate cell |
| throttle_on | output | 1 | Modulation is active |

## Verification
The bench builds the block with ON_TICKS=2, PERIOD_TICKS=8 and HYST_TICKS=5. A tick arrives every third clock, and there is one long stretch with no ticks at all. These short values let the run cover many full periods, a hysteresis restart partway through the count, and exits that have to wait for the period to finish, all within a few hundred cycles. Because the tick is slower than the clock, the run also shows that the phase holds steady between ticks rather than following the core clock.

// File: rtl/thermal_clkmod_pkg.sv
package thermal_clkmod_pkg;
  // Counter width that never collapses to zero bits
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/clkmod_phase_counter.sv
module clkmod_phase_counter
  import thermal_clkmod_pkg::*;
#(
  parameter int ON_TICKS     = 8,
  parameter int PERIOD_TICKS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic adv,
  output logic last,
  output logic on_after_adv
);
  localparam int PW = cnt_w(PERIOD_TICKS);
  localparam logic [PW-1:0] LAST_PH = PW'(PERIOD_TICKS - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      phase <= '0;
    end else if (adv) begin
      phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
    end
  end

  assign last = (phase == LAST_PH);
  // After a wrap the phase is 0, which is always an enabled phase
  assign on_after_adv = last ? 1'b1 : ((int'(phase) + 1) < ON_TICKS);

  // R5
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !start) |=> $stable(phase));
endmodule

// File: rtl/clkmod_hyst_timer.sv
module clkmod_hyst_timer
  import thermal_clkmod_pkg::*;
#(
  parameter int HYST_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic dec,
  output logic expired
);
  localparam int HW = cnt_w(HYST_TICKS + 1);
  localparam logic [HW-1:0] RELOAD = HW'(HYST_TICKS);

  logic [HW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= RELOAD;
    end else if (dec && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // R6
  hyst_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && expired) |=> expired);
endmodule

// File: rtl/thermal_clkmod_gate.sv
module thermal_clkmod_gate
  import thermal_clkmod_pkg::*;
#(
  parameter int ON_TICKS     = 8,
  parameter int PERIOD_TICKS = 32,
  parameter int HYST_TICKS   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic over_temp,
  input  logic fv_at_min,
  input  logic ref_tick,
  output logic clk_en,
  output logic throttle_on
);
  logic engage, leave, last, on_after_adv, expired;
  logic hyst_load, hyst_dec, adv;

  assign engage    = !throttle_on && over_temp && fv_at_min;
  assign leave     = throttle_on && !over_temp && expired && ref_tick && last;
  assign hyst_load = over_temp && (throttle_on || fv_at_min);
  assign hyst_dec  = throttle_on && ref_tick;
  assign adv       = throttle_on && ref_tick;

  clkmod_phase_counter #(
    .ON_TICKS(ON_TICKS), .PERIOD_TICKS(PERIOD_TICKS)
  ) u_phase (
    .clk(clk), .rst(rst), .start(engage), .adv(adv),
    .last(last), .on_after_adv(on_after_adv)
  );

  clkmod_hyst_timer #(
    .HYST_TICKS(HYST_TICKS)
  ) u_hyst (
    .clk(clk), .rst(rst), .load(hyst_load), .dec(hyst_dec),
    .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      throttle_on <= 1'b0;
      clk_en      <= 1'b1;
    end else if (engage) begin
      throttle_on <= 1'b1;
      clk_en      <= 1'b1;
    end else if (leave) begin
      throttle_on <= 1'b0;
      clk_en      <= 1'b1;
    end else if (adv) begin
      clk_en      <= on_after_adv;
    end
  end

  // R2
  idle_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !throttle_on |-> clk_en);
  // R3
  no_lone_engage_chk: assert property (@(posedge clk) disable iff (rst)
    (!throttle_on && !(over_temp && fv_at_min)) |=> !throttle_on);
  // R4
  start_on_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(throttle_on) |-> (clk_en && $past(fv_at_min)));
  // R7
  exit_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(throttle_on) |-> $past(ref_tick && !over_temp));
  // R6
  hyst_armed_chk: assert property (@(posedge clk) disable iff (rst)
    (throttle_on && over_temp && HYST_TICKS > 0) |=> !expired);
endmodule

// File: tb/tb_thermal_clkmod_gate.sv
module tb_thermal_clkmod_gate;
  localparam int ON = 2;
  localparam int PER = 8;
  localparam int HY = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic over_temp = 1'b0, fv_at_min = 1'b0, ref_tick = 1'b0;
  logic clk_en, throttle_on;

  int checks = 0, errors = 0, cyc = 0;
  int tick_gap = 3;
  string req = "R1";

  // reference model state
  int m_act = 0, m_ph = 0, m_hc = 0, m_en = 1;

  always #10 clk = ~clk;

  thermal_clkmod_gate #(.ON_TICKS(ON), .PERIOD_TICKS(PER), .HYST_TICKS(HY)) dut (
    .clk(clk), .rst(rst), .over_temp(over_temp), .fv_at_min(fv_at_min),
    .ref_tick(ref_tick), .clk_en(clk_en), .throttle_on(throttle_on)
  );

  always @(posedge clk) begin
    int ot, fm, tk, eng, ext;
    ot = int'(over_temp); fm = int'(fv_at_min); tk = int'(ref_tick);
    if (rst) begin
      m_act = 0; m_ph = 0; m_hc = 0; m_en = 1;
    end else begin
      eng = (m_act == 0 && ot == 1 && fm == 1) ? 1 : 0;
      ext = (m_act == 1 && ot == 0 && m_hc == 0 && tk == 1 && m_ph == PER - 1) ? 1 : 0;
      if (ot == 1 && (m_act == 1 || fm == 1)) m_hc = HY;
      else if (m_act == 1 && tk == 1 && m_hc > 0) m_hc = m_hc - 1;
      if (eng == 1) begin m_act = 1; m_ph = 0; m_en = 1; end
      else if (ext == 1) begin m_act = 0; m_ph = 0; m_en = 1; end
      else if (m_act == 1 && tk == 1) begin
        m_ph = (m_ph == PER - 1) ? 0 : m_ph + 1;
        m_en = (m_ph < ON) ? 1 : 0;
      end
    end
  end

  task automatic check(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", r, act, exp, cyc);
    end
  endtask

  // one cycle: compare outputs with the model, then drive the next tick
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      check({req, " clk_en"}, int'(clk_en), m_en);
      check({req, " throttle_on"}, int'(throttle_on), m_act);
      ref_tick = (tick_gap > 0 && (cyc % tick_gap) == 0);
    end
  endtask

  initial begin
    int w;
    w = 0;
    while (w < 20000) begin @(posedge clk); w++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    req = "R1";
    step(1);
    check("R1 reset clk_en", int'(clk_en), 1);
    check("R1 reset throttle_on", int'(throttle_on), 0);

    req = "R3"; over_temp = 1'b1; step(20);
    check("R3 over_temp alone", int'(throttle_on), 0);
    over_temp = 1'b0; fv_at_min = 1'b1; step(20);
    check("R3 fv_at_min alone", int'(throttle_on), 0);
    req = "R2"; check("R2 idle enable", int'(clk_en), 1);

    req = "R4"; over_temp = 1'b1;
    step(1);
    check("R4 engage throttle_on", int'(throttle_on), 1);
    check("R4 first phase enabled", int'(clk_en), 1);

    req = "R5"; step(60);
    tick_gap = 0; step(30);
    tick_gap = 3; step(40);

    req = "R8"; fv_at_min = 1'b0; step(40);
    check("R8 still throttling", int'(throttle_on), 1);

    req = "R6"; over_temp = 1'b0; step(9);
    over_temp = 1'b1; step(4);
    over_temp = 1'b0; step(12);
    check("R6 held by restarted timer", int'(throttle_on), 1);

    req = "R7"; step(80);
    check("R7 exited", int'(throttle_on), 0);
    req = "R9"; check("R9 enable after exit", int'(clk_en), 1);

    req = "R7"; fv_at_min = 1'b1; over_temp = 1'b1; step(30);
    over_temp = 1'b0; tick_gap = 1; step(60);
    check("R7 exited fast ticks", int'(throttle_on), 0);
    req = "R2"; step(10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule